// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the byte stream of a received Ethernet frame and decides whether the frame is a wake-up packet. A wake-up packet holds a synchronisation run of at least six 0xFF bytes. The run is followed at once by sixteen back-to-back copies of the 6-byte station address. The pattern may sit anywhere in the frame, and it may appear more than once. A partial or broken pattern restarts the search without losing a later complete one.

A frame only wakes the system when three things hold at its last byte: the pattern was seen, the upstream address filter accepted the destination, and the upstream CRC check reported good. Detection runs only while the wake-enable input is high. A qualifying frame sets a sticky status bit and drives the active-low event output low. Both stay asserted until the host writes one to clear them. Framing, CRC and filtering are done elsewhere, and this block only consumes their result flags.

Top module: `magic_wake_detect`

## Requirements
- R1: After reset, `pmeStatus` is 0 and `pmeN` is 1.
- R2: A frame holding six 0xFF bytes followed immediately by sixteen consecutive copies of the station address sets `pmeStatus` to 1 and `pmeN` to 0 in the cycle after its end-of-frame beat, provided `addrPass`, `crcGood` and `wakeEnable` are all 1 on that beat. Address byte k is `stationAddr[8k+7:8k]`, and byte 0 is sent first.
- R3: A synchronisation run longer than six 0xFF bytes is accepted. The address sequence may begin after any 0xFF byte once six have been seen. Other bytes may come before the pattern.
- R4: A run of fewer than six 0xFF bytes before the address copies, or fewer than sixteen address copies, does not wake.
- R5: A byte that does not match the expected address byte restarts the search. A mismatching byte equal to 0xFF counts as the first byte of a new synchronisation run.
- R6: A frame with several patterns, or with a broken pattern followed by a complete one, wakes.
- R7: If `addrPass` or `crcGood` is 0 on the end-of-frame beat, the frame does not wake.
- R8: While `wakeEnable` is 0, no frame wakes.
- R9: `pmeStatus` and `pmeN` hold their asserted state until a `statusClear` pulse. After the pulse, `pmeStatus` reads 0 and `pmeN` reads 1 in the following cycle. If a wake and a clear occur in the same cycle, the wake wins.
- R10: A start-of-frame beat or a `frameAbort` pulse discards any partial pattern, so bytes before it never combine with bytes after it.
- R11: Once a full pattern is seen, later bytes of the same frame (including 0xFF and unrelated bytes) do not cancel the wake decision made at end of frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inData | input | 8 | Received byte |
| inValid | input | 1 | `inData` carries a byte this cycle |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame; flags are sampled here |
| frameAbort | input | 1 | Pulse: current frame is abandoned |
| addrPass | input | 1 | Destination address accepted by the filter |
| crcGood | input | 1 | Frame CRC checked good |
| stationAddr | input | 48 | Station address, byte k at bits 8k+7:8k |
| wakeEnable | input | 1 | Enables detection |
| statusClear | input | 1 | Write-one-to-clear pulse for the status bit |
| pmeN | output | 1 | Active-low power-management event |
| pmeStatus | output | 1 | Sticky wake status |

## Verification
The bench sweeps the synchronisation run length from zero to nine bytes, which places the threshold between five and six and shows that longer runs still count. It sweeps the copy count around sixteen, and it corrupts the address sequence at every one of its 96 positions, so that no early or late acceptance goes unseen. Separate frames use a mismatching 0xFF as the start of a new run, repeat or restart patterns, clear each qualifying flag or the enable, and split a pattern across an abort or a fresh start-of-frame. Each of these tells the restart and qualification rules apart from a plain match counter.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef struct packed {
    logic fresh;
    logic clearAll;
    logic syncZero;
    logic syncOne;
    logic syncInc;
    logic seqZero;
    logic seqAdvance;
    logic foundSet;
  } mwd_strobe_t;

  typedef struct packed {
    logic isSync;
    logic addrMatch;
    logic syncReady;
    logic inSeq;
    logic lastByte;
    logic found;
  } mwd_flags_t;
endpackage

// File: rtl/mwd_datapath.sv
module mwd_datapath
  import mwd_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int REPEATS    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              inData,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  mwd_strobe_t             strobe,
  output mwd_flags_t              flags
);
  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;

  logic [SW-1:0] syncCnt, effSync, nextSync;
  logic [IW-1:0] addrIdx, effIdx, nextIdx;
  logic [RW-1:0] repCnt, effRep, nextRep;
  logic          found, effFound, nextFound;
  logic [7:0]    addrBytes [ADDR_BYTES];

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_bytes
    assign addrBytes[k] = stationAddr[8*k +: 8];
  end

  // a start-of-frame byte is judged against an empty search state
  always_comb begin
    effSync  = strobe.fresh ? '0 : syncCnt;
    effIdx   = strobe.fresh ? '0 : addrIdx;
    effRep   = strobe.fresh ? '0 : repCnt;
    effFound = strobe.fresh ? 1'b0 : found;
  end

  always_comb begin
    flags.isSync    = (inData == 8'hFF);
    flags.addrMatch = (inData == addrBytes[effIdx]);
    flags.syncReady = (effSync == SW'(SYNC_LEN));
    flags.inSeq     = (effIdx != '0) || (effRep != '0);
    flags.lastByte  = (effIdx == IW'(ADDR_BYTES - 1)) && (effRep == RW'(REPEATS - 1));
    flags.found     = effFound;
  end

  always_comb begin
    nextSync  = effSync;
    nextIdx   = effIdx;
    nextRep   = effRep;
    nextFound = effFound;
    if (strobe.syncZero) nextSync = '0;
    else if (strobe.syncOne) nextSync = SW'(1);
    else if (strobe.syncInc && (effSync != SW'(SYNC_LEN))) nextSync = effSync + SW'(1);
    if (strobe.seqZero) begin
      nextIdx = '0;
      nextRep = '0;
    end else if (strobe.seqAdvance) begin
      if (effIdx == IW'(ADDR_BYTES - 1)) begin
        nextIdx = '0;
        nextRep = effRep + RW'(1);
      end else begin
        nextIdx = effIdx + IW'(1);
      end
    end
    if (strobe.foundSet) nextFound = 1'b1;
    if (strobe.clearAll) begin
      nextSync  = '0;
      nextIdx   = '0;
      nextRep   = '0;
      nextFound = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncCnt <= '0;
      addrIdx <= '0;
      repCnt  <= '0;
      found   <= 1'b0;
    end else begin
      syncCnt <= nextSync;
      addrIdx <= nextIdx;
      repCnt  <= nextRep;
      found   <= nextFound;
    end
  end

  // R3: run counter saturates at the required length
  assert_sync_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    syncCnt <= SW'(SYNC_LEN));

  // R5: byte index never leaves the address
  assert_index_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addrIdx <= IW'(ADDR_BYTES - 1));

  // R10: a clear request empties the whole search state
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearAll |=> (syncCnt == '0) && (addrIdx == '0) && (repCnt == '0) && !found);
endmodule

// File: rtl/mwd_control.sv
module mwd_control
  import mwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        frameAbort,
  input  logic        addrPass,
  input  logic        crcGood,
  input  logic        wakeEnable,
  input  logic        statusClear,
  input  mwd_flags_t  flags,
  output mwd_strobe_t strobe,
  output logic        pmeStatus
);
  logic hitNow;
  logic frameDone;
  logic wakeSet;

  always_comb begin
    strobe       = '0;
    hitNow       = 1'b0;
    strobe.fresh = inValid && inSof;
    if (frameAbort || !wakeEnable) begin
      strobe.clearAll = 1'b1;
    end else if (inValid) begin
      if (flags.inSeq) begin
        if (flags.addrMatch) begin
          if (flags.lastByte) begin
            hitNow          = 1'b1;
            strobe.seqZero  = 1'b1;
            strobe.syncZero = 1'b1;
            strobe.foundSet = 1'b1;
          end else begin
            strobe.seqAdvance = 1'b1;
          end
        end else begin
          strobe.seqZero = 1'b1;
          if (flags.isSync) strobe.syncOne = 1'b1;
          else strobe.syncZero = 1'b1;
        end
      end else if (flags.syncReady && flags.addrMatch) begin
        strobe.seqAdvance = 1'b1;
      end else if (flags.isSync) begin
        strobe.syncInc = 1'b1;
      end else begin
        strobe.syncZero = 1'b1;
      end
      if (inEof) strobe.clearAll = 1'b1;
    end
  end

  assign frameDone = inValid && inEof && wakeEnable && !frameAbort;
  assign wakeSet   = frameDone && (flags.found || hitNow) && addrPass && crcGood;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pmeStatus <= 1'b0;
    else        pmeStatus <= wakeSet || (pmeStatus && !statusClear);
  end

  // R7: status rises only after a qualified end of frame
  assert_rise_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pmeStatus) |-> $past(inValid && inEof && addrPass && crcGood && wakeEnable));

  // R9: status is sticky without a clear
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pmeStatus && !statusClear) |=> pmeStatus);

  // R9: status falls only on a clear request
  assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pmeStatus) |-> $past(statusClear));
endmodule

// File: rtl/magic_wake_detect.sv
module magic_wake_detect
  import mwd_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int REPEATS    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              inData,
  input  logic                    inValid,
  input  logic                    inSof,
  input  logic                    inEof,
  input  logic                    frameAbort,
  input  logic                    addrPass,
  input  logic                    crcGood,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    wakeEnable,
  input  logic                    statusClear,
  output logic                    pmeN,
  output logic                    pmeStatus
);
  mwd_strobe_t strobe;
  mwd_flags_t  flags;

  mwd_datapath #(
    .SYNC_LEN  (SYNC_LEN),
    .ADDR_BYTES(ADDR_BYTES),
    .REPEATS   (REPEATS)
  ) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .inData     (inData),
    .stationAddr(stationAddr),
    .strobe     (strobe),
    .flags      (flags)
  );

  mwd_control u_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inSof      (inSof),
    .inEof      (inEof),
    .frameAbort (frameAbort),
    .addrPass   (addrPass),
    .crcGood    (crcGood),
    .wakeEnable (wakeEnable),
    .statusClear(statusClear),
    .flags      (flags),
    .strobe     (strobe),
    .pmeStatus  (pmeStatus)
  );

  assign pmeN = !pmeStatus;
endmodule

// File: tb/magic_wake_detect_bench.sv
module magic_wake_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STATION = 48'hA5C35E712402;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, frameAbort = 1'b0;
  logic        addrPass = 1'b0, crcGood = 1'b0, wakeEnable = 1'b1, statusClear = 1'b0;
  logic        pmeN, pmeStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] frm [0:511];
  int flen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  magic_wake_detect u_magic_wake_detect (
    .clk(clk), .rst_n(rst_n), .inData(inData), .inValid(inValid), .inSof(inSof),
    .inEof(inEof), .frameAbort(frameAbort), .addrPass(addrPass), .crcGood(crcGood),
    .stationAddr(STATION), .wakeEnable(wakeEnable), .statusClear(statusClear),
    .pmeN(pmeN), .pmeStatus(pmeStatus)
  );

  function automatic logic [7:0] addrByte(int k);
    return STATION[8*(k % 6) +: 8];
  endfunction

  task automatic check(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic checkWake(input logic expected, input string tag);
    check(pmeStatus, expected, {tag, " status"});
    check(pmeN, !expected, {tag, " event"});
  endtask

  task automatic newFrame();
    flen = 0;
  endtask

  task automatic put(input logic [7:0] b);
    frm[flen] = b;
    flen++;
  endtask

  task automatic putFf(input int n);
    for (int i = 0; i < n; i++) put(8'hFF);
  endtask

  // bytes [first, first+n) of the address sequence; position bad replaced by 0x00
  task automatic putSeq(input int first, input int n, input int bad);
    for (int i = first; i < first + n; i++) put((i == bad) ? 8'h00 : addrByte(i));
  endtask

  task automatic putJunk();
    put(8'h12); put(8'h34); put(8'h56);
  endtask

  task automatic sendFrame(input logic pass, input logic crc, input bit withEof, input bit clrAtEof);
    for (int i = 0; i < flen; i++) begin
      inData   = frm[i];
      inValid  = 1'b1;
      inSof    = (i == 0);
      inEof    = withEof && (i == flen - 1);
      addrPass = pass;
      crcGood  = crc;
      statusClear = clrAtEof && (i == flen - 1);
      @(negedge clk);
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; statusClear = 1'b0;
    addrPass = 1'b0; crcGood = 1'b0;
  endtask

  task automatic clearStatus(input string tag);
    statusClear = 1'b1;
    @(negedge clk);
    statusClear = 1'b0;
    checkWake(1'b0, tag);
  endtask

  task automatic goodPattern();
    putFf(6); putSeq(0, 96, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkWake(1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkWake(1'b0, "R1 after reset");

    // R2 R3 R4: sync run length sweep
    for (int n = 0; n <= 9; n++) begin
      newFrame(); putJunk(); putFf(n); putSeq(0, 96, -1); put(8'h00); put(8'h77);
      sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
      checkWake(n >= 6, $sformatf("R2 R3 R4 run=%0d", n));
      clearStatus("R9 clear after run sweep");
    end

    // R2 R4 R11: copy count sweep
    for (int r = 14; r <= 17; r++) begin
      newFrame(); putJunk(); putFf(6); putSeq(0, 6*r, -1); put(8'h3C);
      sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
      checkWake(r >= 16, $sformatf("R4 R11 copies=%0d", r));
      clearStatus("R9 clear after copy sweep");
    end

    // R5: corruption at every position of the sequence
    for (int p = 0; p < 96; p++) begin
      newFrame(); putJunk(); putFf(6); putSeq(0, 96, p); put(8'h00);
      sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
      checkWake(1'b0, $sformatf("R5 corrupt pos=%0d", p));
    end

    // R5: a mismatching 0xFF starts a new run
    for (int k = 5; k <= 6; k++) begin
      newFrame(); putJunk(); putFf(6); putSeq(0, 3, -1); putFf(k); putSeq(0, 96, -1);
      sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
      checkWake(k >= 6, $sformatf("R5 restart ff=%0d", k));
      clearStatus("R9 clear after restart");
    end

    // R6: broken then complete, and two complete patterns
    newFrame(); putJunk(); putFf(6); putSeq(0, 96, 40); goodPattern(); put(8'h01);
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b1, "R6 broken then complete");
    clearStatus("R9 clear");
    newFrame(); putJunk(); goodPattern(); put(8'h01); goodPattern();
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b1, "R6 two patterns");
    clearStatus("R9 clear");

    // R7: flag qualification
    newFrame(); putJunk(); goodPattern(); put(8'h01);
    sendFrame(1'b0, 1'b1, 1'b1, 1'b0);
    checkWake(1'b0, "R7 filter reject");
    sendFrame(1'b1, 1'b0, 1'b1, 1'b0);
    checkWake(1'b0, "R7 crc bad");
    sendFrame(1'b0, 1'b0, 1'b1, 1'b0);
    checkWake(1'b0, "R7 both bad");

    // R8: enable low
    wakeEnable = 1'b0;
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b0, "R8 disabled");
    wakeEnable = 1'b1;
    @(negedge clk);

    // R9: sticky, ignores non-waking frames, set wins over clear
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b1, "R9 set");
    repeat (20) @(negedge clk);
    checkWake(1'b1, "R9 held idle");
    newFrame(); putJunk(); put(8'h00);
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b1, "R9 held after plain frame");
    clearStatus("R9 cleared");
    newFrame(); putJunk(); goodPattern();
    sendFrame(1'b1, 1'b1, 1'b1, 1'b1);
    checkWake(1'b1, "R9 set wins over clear");
    clearStatus("R9 cleared again");

    // R10: abort splits a pattern
    newFrame(); putJunk(); putFf(6); putSeq(0, 50, -1);
    sendFrame(1'b1, 1'b1, 1'b0, 1'b0);
    frameAbort = 1'b1;
    @(negedge clk);
    frameAbort = 1'b0;
    newFrame(); putSeq(50, 46, -1);
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b0, "R10 abort split");

    // R10: new start-of-frame splits a pattern
    newFrame(); putJunk(); putFf(6); putSeq(0, 50, -1);
    sendFrame(1'b1, 1'b1, 1'b0, 1'b0);
    newFrame(); putSeq(50, 46, -1);
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b0, "R10 sof split");

    // R11: trailing bytes after a found pattern
    newFrame(); putJunk(); goodPattern(); putFf(3); putSeq(0, 4, -1); put(8'h00); putFf(7);
    sendFrame(1'b1, 1'b1, 1'b1, 1'b0);
    checkWake(1'b1, "R11 trailing bytes");
    clearStatus("R9 final clear");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule